// File: doc/BRIEF.md
# SPI Master Transfer Engine, Second-Edge Sampling Format

This block is the transmit and receive engine of an SPI master. It uses the clock format in which the master launches a bit on the first SCK edge of each bit pair and samples the incoming line on the second edge. Software-side logic drives the block through a small register-style port. A write to the data port queues a byte in a one-entry holding slot. The engine moves the byte into its shift register, clocks eight bits out on `mosi`, and gathers eight bits from `miso`. When it finishes, it returns the received byte on `rx_data` and raises a completion flag.

Three settings are configurable: the idle level of SCK, the bit order, and the SCK half-period, which is `cfg_div + 1` system clocks. A byte that is already in the slot when a transfer ends is chained straight on. The next first edge follows the last edge by exactly one half-period, and slave-select stays asserted. A transfer that starts from idle gets a one half-period lead after slave-select falls. A transfer that ends without a queued byte gets a one half-period tail, followed by at least one half-period with slave-select high.

The controller has five states:
- IDLE: nothing queued.
- LEAD: slave-select is low, waiting for the first edge.
- SHIFT: edges 2 to 16 are produced.
- TAIL: the half-period after the last edge, ending in completion.
- GAP: slave-select is high for the minimum idle time.

The transitions are:
- IDLE→LEAD when the slot is full.
- LEAD→SHIFT on the half-period tick, which issues edge 1.
- SHIFT→TAIL on the tick that issues edge 16.
- TAIL→SHIFT on the tick when the slot is full. This is the chain, and it issues edge 1 of the next byte.
- TAIL→GAP on the tick when the slot is empty.
- GAP→IDLE on the tick.

Top module: `spi_p1_master`

## Requirements
- R1: Each byte takes exactly 16 SCK edges. `mosi` changes only on odd-numbered edges (1, 3, …, 15), and `miso` is sampled on even-numbered edges (2, 4, …, 16), so a slave that samples on even edges receives the written byte, and `rx_data` holds the byte the slave sent.
- R2: While no transfer is running, `sck` equals `cfg_cpol` (0 gives an idle-low clock, 1 gives idle-high). Edge 1 always moves `sck` away from that level.
- R3: With `cfg_lsb_first` = 0, bit 7 travels first in both directions. With `cfg_lsb_first` = 1, bit 0 travels first in both directions.
- R4: Consecutive SCK edges within a transfer are exactly `cfg_div + 1` system clocks apart.
- R5: `done_flag` is set exactly `cfg_div + 1` clocks after the 16th edge, and `rx_data` takes the received byte in that same cycle.
- R6: When a byte is waiting at the end of a transfer, edge 1 of that byte comes exactly one half-period after edge 16 of the previous byte, with `ss_n` held low throughout.
- R7: With `cfg_auto_ss` = 1, `ss_n` is low on every SCK edge. Edge 1 of a transfer started from idle comes one half-period after `ss_n` falls, and `ss_n` stays high for at least one half-period between separate transfers. With `cfg_auto_ss` = 0, `ss_n` stays high.
- R8: A write while the holding slot is full is ignored: the queued byte is unchanged and no extra transfer happens. The write sets the sticky `overrun` bit. `buf_ready` is 1 exactly when the slot is empty.
- R9: A pulse on `rd_en` or `flag_clr` clears `done_flag`. `flag_clr` also clears `overrun`. `rx_data` holds its value until the next completion.
- R10: A synchronous active-high `rst` returns `sck` to its idle level. It drives `ss_n` high, and it clears `busy`, `done_flag`, `overrun` and the holding slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_auto_ss | input | 1 | 1 = engine drives slave-select |
| cfg_div | input | DIV_W | SCK half-period minus one, in system clocks |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Data-port read strobe, clears the flag |
| flag_clr | input | 1 | Write-one clear of flag and overrun |
| rx_data | output | DATA_W | Last received byte |
| done_flag | output | 1 | Transfer-complete flag |
| overrun | output | 1 | Sticky ignored-write indication |
| buf_ready | output | 1 | Holding slot empty |
| busy | output | 1 | Controller not in IDLE |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave-select |
| miso | input | 1 | Serial data in |

## Verification
Several properties are checked on every cycle by the assertions:
- SCK rests at its idle level in IDLE, and the edge counter never passes 16.
- The flag rises only out of TAIL, and a chain leaves TAIL straight into SHIFT with the clock already moved.
- A sampled `miso` bit lands at the end of the shift register chosen by the bit order.
- A write into a full slot leaves the slot unchanged and sets `overrun`.

Other properties need the bench's scenarios and its model slave. These are the end-to-end byte contents under all four polarity and order combinations. They also include the exact spacing between edges, from `ss_n` fall to edge 1, from edge 16 to the flag, and between chained bytes, plus the minimum high time of `ss_n` between separate transfers and the recovery after a reset in the middle of a transfer.

// File: rtl/spi_p1_pkg.sv
package spi_p1_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } p1_state_e;
endpackage

// File: rtl/spi_p1_halfcnt.sv
module spi_p1_halfcnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    half_period_min_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/spi_p1_txslot.sv
module spi_p1_txslot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pull,
    input  logic              ovr_clr,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else begin
            if (pull) begin
                full <= 1'b0;
            end else if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
            if (wr_en && full) begin
                overrun <= 1'b1;
            end else if (ovr_clr) begin
                overrun <= 1'b0;
            end
        end
    end

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> overrun);

    // R8
    slot_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pull) |=> (full && $stable(data)));
endmodule

// File: rtl/spi_p1_shifter.sv
module spi_p1_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drive,
    input  logic              sample,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] sh_q;
    logic              mosi_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] src;

    assign src     = load ? load_data : sh_q;
    assign mosi    = mosi_q;
    assign rx_data = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            mosi_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            if (capture) begin
                rx_q <= sh_q;
            end
            if (load) begin
                sh_q <= load_data;
            end else if (sample) begin
                if (lsb_first) begin
                    sh_q <= {miso, sh_q[DATA_W-1:1]};
                end else begin
                    sh_q <= {sh_q[DATA_W-2:0], miso};
                end
            end
            if (drive) begin
                mosi_q <= lsb_first ? src[0] : src[DATA_W-1];
            end
        end
    end

    // R3
    sample_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (sample && !load && !capture) |=>
            ($past(lsb_first) ? (sh_q[DATA_W-1] == $past(miso)) : (sh_q[0] == $past(miso))));
endmodule

// File: rtl/spi_p1_master.sv
module spi_p1_master
    import spi_p1_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_lsb_first,
    input  logic              cfg_auto_ss,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_flag,
    output logic              overrun,
    output logic              buf_ready,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n,
    input  logic              miso
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES + 1);
    localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES);
    localparam logic [ECNT_W-1:0] PRE_LAST  = ECNT_W'(EDGES - 1);

    p1_state_e         state_q, state_d;
    logic              tick;
    logic              run;
    logic              slot_full;
    logic [DATA_W-1:0] slot_data;
    logic              pull;
    logic              first_edge;
    logic              edge_ev;
    logic              drive;
    logic              sample;
    logic              done_set;
    logic [ECNT_W-1:0] edge_q;
    logic [ECNT_W-1:0] edge_nxt;
    logic              sck_q;
    logic              done_q;

    assign run = (state_q != ST_IDLE);

    spi_p1_halfcnt #(.DIV_W(DIV_W)) u_halfcnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg_div),
        .tick (tick)
    );

    spi_p1_txslot #(.DATA_W(DATA_W)) u_txslot (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pull    (pull),
        .ovr_clr (flag_clr),
        .full    (slot_full),
        .data    (slot_data),
        .overrun (overrun)
    );

    spi_p1_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .lsb_first (cfg_lsb_first),
        .load      (pull),
        .load_data (slot_data),
        .drive     (drive),
        .sample    (sample),
        .capture   (done_set),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (slot_full) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && edge_q == PRE_LAST) state_d = ST_TAIL;
            ST_TAIL:  if (tick) state_d = slot_full ? ST_SHIFT : ST_GAP;
            ST_GAP:   if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Per-cycle control outputs of the state machine
    always_comb begin
        first_edge = tick && ((state_q == ST_LEAD) ||
                              (state_q == ST_TAIL && slot_full));
        edge_ev    = first_edge || (tick && state_q == ST_SHIFT);
        edge_nxt   = first_edge ? ECNT_W'(1) : edge_q + 1'b1;
        drive      = edge_ev && edge_nxt[0];
        sample     = edge_ev && !edge_nxt[0];
        pull       = slot_full && ((state_q == ST_IDLE) ||
                                   (state_q == ST_TAIL && tick));
        done_set   = tick && (state_q == ST_TAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (edge_ev) begin
                edge_q <= edge_nxt;
                sck_q  <= ~sck_q;
            end
            if (done_set) begin
                done_q <= 1'b1;
            end else if (rd_en || flag_clr) begin
                done_q <= 1'b0;
            end
        end
    end

    assign sck       = sck_q ^ cfg_cpol;
    assign ss_n      = !(cfg_auto_ss && (state_q == ST_LEAD ||
                                         state_q == ST_SHIFT ||
                                         state_q == ST_TAIL));
    assign done_flag = done_q;
    assign busy      = run;
    assign buf_ready = !slot_full;

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (sck == cfg_cpol));

    // R1
    edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
        edge_q <= LAST_EDGE);

    // R5
    flag_from_tail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(state_q == ST_TAIL && tick));

    // R6
    chain_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL && tick && slot_full) |=>
            (state_q == ST_SHIFT && sck != cfg_cpol));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ss_n && !done_flag && !busy && buf_ready));
endmodule

// File: tb/tb_spi_p1_master.sv
module tb_spi_p1_master;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_cpol = 1'b0;
    logic          cfg_lsb_first = 1'b0;
    logic          cfg_auto_ss = 1'b1;
    logic [VW-1:0] cfg_div = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic [DW-1:0] rx_data;
    logic          done_flag, overrun, buf_ready, busy, sck, mosi, ss_n;
    logic          miso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_p1_master #(.DATA_W(DW), .DIV_W(VW)) dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
        .cfg_auto_ss(cfg_auto_ss), .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .flag_clr(flag_clr), .rx_data(rx_data), .done_flag(done_flag),
        .overrun(overrun), .buf_ready(buf_ready), .busy(busy), .sck(sck), .mosi(mosi),
        .ss_n(ss_n), .miso(miso)
    );

    int checks = 0, errors = 0, mchk = 0, merr = 0, wd = 0;
    logic [DW-1:0] sent [0:255];
    logic [DW-1:0] cap  [0:255];
    int nwr = 0;

    function automatic logic [DW-1:0] slave_byte(input int k);
        return DW'(8'h3C ^ (k * 29));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mcheck(input bit ok, input string req, input longint act, input longint exp);
        mchk++;
        if (!ok) begin
            merr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks + mchk + wd, errors + merr + wd);
        $finish;
    endtask

    // Model slave and timing monitor
    int   cyc = 0, edges = 0, burst_edges = 0, last_edge = 0;
    int   ss_rise_cyc = 0, ss_fall_cyc = 0, due = 0, due_k = 0, last_done_gap = -1;
    bit   have_rise = 0, pend = 0;
    logic prev_sck = 1'b0, prev_ss = 1'b1, prev_done = 1'b0;

    always @(negedge clk) begin
        int h, e, k, i;
        logic [DW-1:0] sb;
        h = int'(cfg_div) + 1;
        if (rst) begin
            edges = 0; burst_edges = 0; pend = 0; have_rise = 0;
        end else begin
            if (ss_n !== prev_ss) begin
                if (ss_n) begin
                    ss_rise_cyc = cyc; have_rise = 1;
                end else begin
                    ss_fall_cyc = cyc;
                    if (have_rise)
                        mcheck(cyc - ss_rise_cyc >= h, "R7 ss high time", cyc - ss_rise_cyc, h);
                end
            end
            if (!busy) burst_edges = 0;
            if (sck !== prev_sck && busy) begin
                edges++; burst_edges++;
                e = ((edges - 1) % 16) + 1;
                k = (edges - 1) / 16;
                if (burst_edges == 1) begin
                    if (cfg_auto_ss)
                        mcheck(cyc - ss_fall_cyc == h, "R7 lead time", cyc - ss_fall_cyc, h);
                end else if (e == 1) begin
                    mcheck(cyc - last_edge == h, "R6 chained gap", cyc - last_edge, h);
                end else begin
                    mcheck(cyc - last_edge == h, "R4 edge spacing", cyc - last_edge, h);
                end
                if (cfg_auto_ss) mcheck(ss_n == 1'b0, "R7 ss low on edge", ss_n, 0);
                if (e == 1) mcheck(sck == !cfg_cpol, "R2 first edge leaves idle", sck, !cfg_cpol);
                sb = slave_byte(k);
                if (e % 2 == 1) begin
                    i = (e - 1) / 2;
                    miso = cfg_lsb_first ? sb[i] : sb[DW-1-i];
                end else begin
                    i = (e - 2) / 2;
                    if (cfg_lsb_first) cap[k][i] = mosi;
                    else cap[k][DW-1-i] = mosi;
                end
                if (e == 16) begin
                    pend = 1; due = cyc + h; due_k = k;
                end
                last_edge = cyc;
            end
            if (pend && cyc == due) begin
                pend = 0;
                mcheck(done_flag == 1'b1, "R5 flag at half period", done_flag, 1);
                mcheck(rx_data == slave_byte(due_k), "R1 R3 received byte", rx_data, slave_byte(due_k));
            end
            if (done_flag && !prev_done) last_done_gap = cyc - last_edge;
        end
        prev_sck = sck; prev_ss = ss_n; prev_done = done_flag;
        cyc++;
    end

    task automatic write_byte(input logic [DW-1:0] d, input bit counts);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        if (counts) begin sent[nwr] = d; nwr++; end
    endtask

    task automatic wait_complete();
        do @(negedge clk); while (!(edges == 16 * nwr && !busy));
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        wd = 1;
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check(sck == 1'b0 && ss_n == 1'b1 && busy == 1'b0, "R10 pins in reset", {sck, ss_n, busy}, 3'b010);
        check(done_flag == 0 && overrun == 0 && buf_ready == 1, "R10 status in reset", {done_flag, overrun, buf_ready}, 3'b001);
        rst = 1'b0;
        @(negedge clk);

        // Sweep of polarity, order and divider with two chained bytes each
        for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 2; o++) begin
                for (int d = 0; d < 3; d++) begin
                    int base;
                    logic [DW-1:0] b0, b1;
                    cfg_cpol = p[0]; cfg_lsb_first = o[0]; cfg_div = VW'(d);
                    @(negedge clk);
                    check(sck == cfg_cpol, "R2 idle level", sck, cfg_cpol);
                    base = nwr;
                    b0 = DW'(8'h81 ^ (base * 53));
                    b1 = DW'(8'h5A + base * 7);
                    write_byte(b0, 1);
                    do @(negedge clk); while (!buf_ready);
                    write_byte(b1, 1);
                    wait_complete();
                    check(cap[base] == b0, "R1 R3 first byte on mosi", cap[base], b0);
                    check(cap[base+1] == b1, "R6 chained byte on mosi", cap[base+1], b1);
                    check(edges == 16 * nwr, "R1 edge count", edges, 16 * nwr);
                    check(sck == cfg_cpol, "R2 idle after", sck, cfg_cpol);
                    repeat (3) @(negedge clk);
                    check(rx_data == slave_byte(base + 1), "R9 rx held", rx_data, slave_byte(base + 1));
                    pulse_rd();
                    check(done_flag == 1'b0, "R9 read clears flag", done_flag, 0);
                end
            end
        end

        // Separate transfers: lead, tail, idle time and flag timing
        cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; cfg_div = VW'(1);
        pulse_rd();
        write_byte(8'hC3, 1);
        do @(negedge clk); while (ss_n);
        do @(negedge clk); while (!ss_n);
        write_byte(8'h3C, 1);
        wait_complete();
        check(last_done_gap == 2, "R5 flag rise after last edge", last_done_gap, 2);
        check(cap[nwr-2] == 8'hC3 && cap[nwr-1] == 8'h3C, "R7 separate bytes", {cap[nwr-2], cap[nwr-1]}, 16'hC33C);

        // Slave-select left to software
        begin
            int low_seen = 0;
            cfg_auto_ss = 1'b0;
            write_byte(8'h96, 1);
            do begin
                @(negedge clk);
                if (!ss_n) low_seen++;
            end while (!(edges == 16 * nwr && !busy));
            check(low_seen == 0, "R7 ss held high", low_seen, 0);
            check(cap[nwr-1] == 8'h96, "R7 byte without ss", cap[nwr-1], 8'h96);
            cfg_auto_ss = 1'b1;
        end

        // Overrun: a third write while the slot is full
        cfg_div = VW'(3);
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        write_byte(8'hA1, 1);
        write_byte(8'hB2, 1);
        check(buf_ready == 1'b0, "R8 slot full", buf_ready, 0);
        write_byte(8'hEE, 0);
        check(overrun == 1'b1, "R8 overrun set", overrun, 1);
        wait_complete();
        repeat (4 * 4) @(negedge clk);
        check(edges == 16 * nwr, "R8 no extra transfer", edges, 16 * nwr);
        check(cap[nwr-1] == 8'hB2, "R8 queued byte kept", cap[nwr-1], 8'hB2);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check(overrun == 1'b0 && done_flag == 1'b0, "R9 clear write", {overrun, done_flag}, 0);

        // Reset in the middle of a transfer
        cfg_cpol = 1'b1;
        @(negedge clk);
        write_byte(8'h77, 1);
        do @(negedge clk); while (edges < 16 * (nwr - 1) + 5);
        rst = 1'b1;
        @(negedge clk);
        check(sck == 1'b1 && ss_n == 1'b1 && busy == 1'b0, "R10 pins after reset", {sck, ss_n, busy}, 3'b110);
        check(done_flag == 0 && buf_ready == 1 && overrun == 0, "R10 status after reset", {done_flag, buf_ready, overrun}, 3'b010);
        @(negedge clk);
        rst = 1'b0;
        nwr = 0;
        @(negedge clk);
        write_byte(8'h4D, 1);
        wait_complete();
        check(cap[0] == 8'h4D, "R10 recovery transfer", cap[0], 8'h4D);
        check(rx_data == slave_byte(0), "R10 recovery rx", rx_data, slave_byte(0));

        repeat (5) @(negedge clk);
        report();
    end
endmodule